// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block merges per-source interrupt flags, enables and priority bits into one request toward a CPU, together with the address of the handler to branch to. It runs in one of two modes, chosen by a level input. In legacy mode there is one level. The first global enable gates every source, and the second global enable also gates the peripheral sources. In priority mode each source is either high or low priority. The first global enable gates the high level and the second gates the low level. Each level has its own vector.

The CPU acknowledges a request with a one-cycle take strobe. The controller then clears the global enable of the level being serviced and records that a handler of that level is running. A return strobe undoes the most recent entry. A high-priority request can pre-empt a running low-priority handler. A low-priority request is held off while a high-priority handler runs. A separate wake output flags any enabled, set source, whatever the global enables are.

Top module: `two_level_intc`

## Requirements
- R1: After reset both global enables read 0 on `ge_state`, every priority bit is 1 (high), no handler is recorded as running, and `irq_req` is 0.
- R2: `wake` is 1 exactly when some source has both its flag and its enable set. It does not depend on the global enables or the mode.
- R3: In legacy mode (`prio_mode`=0) all requests use vector 0x000008. Sources with index below `N_CORE` request when global enable bit 0 is 1. Sources at or above `N_CORE` need both bit 0 and bit 1. Priority bits have no effect.
- R4: In priority mode a pending source whose priority bit is 1 raises `irq_req` with vector 0x000008 whenever global enable bit 0 is 1.
- R5: In priority mode a pending source whose priority bit is 0 raises `irq_req` with vector 0x000018 when global enable bit 1 is 1. A grantable high request always wins over it.
- R6: `irq_ack` while `irq_req` is 1 clears the global enable of the served level from the next cycle: bit 0 for the 0x000008 vector, bit 1 for 0x000018. Ack takes precedence over a same-cycle `ge_wr` or `irq_reti`.
- R7: While a low-priority handler runs, a grantable high-priority request is still raised.
- R8: While a high-priority handler runs, no low-priority request is raised, even with global enable bit 1 set.
- R9: `irq_reti` ends the most recent handler. If a high handler is running it sets bit 0, otherwise if a low handler is running it sets bit 1. With no handler running, `irq_reti` changes nothing.
- R10: `ge_wr` loads `ge_wdata` into the global enables (bit 0 high/all, bit 1 low/peripheral). `pri_wr` loads `pri_wdata` into the priority bits, and the new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_flag | input | N_SRC | Interrupt flag per source |
| src_en | input | N_SRC | Interrupt enable per source |
| pri_wr | input | 1 | Load strobe for the priority bits |
| pri_wdata | input | N_SRC | New priority bits (1 high, 0 low) |
| ge_wr | input | 1 | Load strobe for the global enables |
| ge_wdata | input | 2 | New global enables (bit 0 high/all, bit 1 low/peripheral) |
| prio_mode | input | 1 | 1 selects two-level priority mode |
| irq_ack | input | 1 | CPU takes the presented request |
| irq_reti | input | 1 | CPU returns from a handler |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | ADDR_W | Vector of the presented request |
| wake | output | 1 | Wake-from-sleep indication |
| ge_state | output | 2 | Current global enable bits |

## Verification
`irq_req`, `irq_vec` and `wake` are combinational from the inputs and the held state. A change in flags, enables or mode is therefore due in the same cycle. Loads, acknowledges and returns act on the rising edge, so their effect on `ge_state` and on the request is due one cycle later. The driver applies each stimulus on the falling edge. Strobes are held across exactly one rising edge. Expected items are queued only after that edge has passed, and the monitor compares them before the next rising edge. Each result is read in the cycle it is due.

// File: rtl/intc_pkg.sv
package intc_pkg;
   // Global enable pair: bit 0 gates the high level (legacy: all),
   // bit 1 gates the low level (legacy: peripherals).
   typedef struct packed {
      logic lo_en;
      logic hi_en;
   } ge_t;

   typedef enum logic [0:0] {
      LVL_LO = 1'b0,
      LVL_HI = 1'b1
   } lvl_e;
endpackage

// File: rtl/intc_gate.sv
module intc_gate #(
   parameter int N_SRC  = 8,
   parameter int N_CORE = 3
) (
   input  logic [N_SRC-1:0] flag,
   input  logic [N_SRC-1:0] en,
   input  logic [N_SRC-1:0] pri,
   output logic             any_pend,
   output logic             core_pend,
   output logic             per_pend,
   output logic             hi_pend,
   output logic             lo_pend
);
   localparam int N_PER = N_SRC - N_CORE;

   logic [N_SRC-1:0] pend;
   assign pend     = flag & en;
   assign any_pend = |pend;
   assign hi_pend  = |(pend & pri);
   assign lo_pend  = |(pend & ~pri);

   generate
      if (N_CORE == 0) begin : g_no_core
         assign core_pend = 1'b0;
      end else begin : g_core
         assign core_pend = |pend[N_CORE-1:0];
      end
      if (N_PER == 0) begin : g_no_per
         assign per_pend = 1'b0;
      end else begin : g_per
         assign per_pend = |pend[N_SRC-1:N_CORE];
      end
   endgenerate
endmodule

// File: rtl/intc_state.sv
module intc_state
   import intc_pkg::*;
#(
   parameter int N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pri_wr,
   input  logic [N_SRC-1:0] pri_wdata,
   input  logic             ge_wr,
   input  ge_t              ge_wdata,
   input  logic             take,
   input  lvl_e             take_lvl,
   input  logic             reti,
   output logic [N_SRC-1:0] pri,
   output ge_t              ge,
   output logic             hi_act,
   output logic             lo_act
);
   ge_t  ge_n;
   logic hi_n, lo_n;

   always_comb begin
      ge_n = ge;
      hi_n = hi_act;
      lo_n = lo_act;
      if (ge_wr) ge_n = ge_wdata;
      if (reti) begin
         if (hi_act) begin
            ge_n.hi_en = 1'b1;
            hi_n       = 1'b0;
         end else if (lo_act) begin
            ge_n.lo_en = 1'b1;
            lo_n       = 1'b0;
         end
      end
      if (take) begin
         if (take_lvl == LVL_HI) begin
            ge_n.hi_en = 1'b0;
            hi_n       = 1'b1;
         end else begin
            ge_n.lo_en = 1'b0;
            lo_n       = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ge     <= '0;
         hi_act <= 1'b0;
         lo_act <= 1'b0;
         pri    <= '1;
      end else begin
         ge     <= ge_n;
         hi_act <= hi_n;
         lo_act <= lo_n;
         if (pri_wr) pri <= pri_wdata;
      end
   end
endmodule

// File: rtl/intc_arb.sv
module intc_arb
   import intc_pkg::*;
#(
   parameter int              ADDR_W = 21,
   parameter logic [ADDR_W-1:0] HI_VEC = 'h8,
   parameter logic [ADDR_W-1:0] LO_VEC = 'h18
) (
   input  logic              prio_mode,
   input  ge_t               ge,
   input  logic              hi_act,
   input  logic              core_pend,
   input  logic              per_pend,
   input  logic              hi_pend,
   input  logic              lo_pend,
   output logic              req,
   output lvl_e              lvl,
   output logic [ADDR_W-1:0] vec
);
   logic hi_sel, lo_sel;

   always_comb begin
      if (prio_mode) begin
         hi_sel = ge.hi_en & hi_pend;
         lo_sel = ge.lo_en & lo_pend & ~hi_act & ~hi_sel;
      end else begin
         hi_sel = ge.hi_en & (core_pend | (ge.lo_en & per_pend));
         lo_sel = 1'b0;
      end
   end

   assign req = hi_sel | lo_sel;
   assign lvl = hi_sel ? LVL_HI : LVL_LO;
   assign vec = hi_sel ? HI_VEC : LO_VEC;
endmodule

// File: rtl/two_level_intc.sv
module two_level_intc
   import intc_pkg::*;
#(
   parameter int                N_SRC  = 8,
   parameter int                N_CORE = 3,
   parameter int                ADDR_W = 21,
   parameter logic [ADDR_W-1:0] HI_VEC = 'h000008,
   parameter logic [ADDR_W-1:0] LO_VEC = 'h000018
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_flag,
   input  logic [N_SRC-1:0]  src_en,
   input  logic              pri_wr,
   input  logic [N_SRC-1:0]  pri_wdata,
   input  logic              ge_wr,
   input  logic [1:0]        ge_wdata,
   input  logic              prio_mode,
   input  logic              irq_ack,
   input  logic              irq_reti,
   output logic              irq_req,
   output logic [ADDR_W-1:0] irq_vec,
   output logic              wake,
   output logic [1:0]        ge_state
);
   generate
      if (N_SRC < 1) begin : g_bad_nsrc
         $error("two_level_intc: N_SRC must be at least 1");
      end
      if (N_CORE < 0 || N_CORE > N_SRC) begin : g_bad_ncore
         $error("two_level_intc: N_CORE must lie in 0..N_SRC");
      end
      if (HI_VEC == LO_VEC) begin : g_bad_vec
         $error("two_level_intc: the two vectors must differ");
      end
   endgenerate

   logic [N_SRC-1:0] pri;
   ge_t              ge;
   logic             hi_act, lo_act;
   logic             core_pend, per_pend, hi_pend, lo_pend;
   lvl_e             lvl;
   logic             take;

   intc_gate #(.N_SRC(N_SRC), .N_CORE(N_CORE)) u_gate (
      .flag(src_flag), .en(src_en), .pri(pri),
      .any_pend(wake), .core_pend(core_pend), .per_pend(per_pend),
      .hi_pend(hi_pend), .lo_pend(lo_pend)
   );

   intc_arb #(.ADDR_W(ADDR_W), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)) u_arb (
      .prio_mode(prio_mode), .ge(ge), .hi_act(hi_act),
      .core_pend(core_pend), .per_pend(per_pend),
      .hi_pend(hi_pend), .lo_pend(lo_pend),
      .req(irq_req), .lvl(lvl), .vec(irq_vec)
   );

   assign take = irq_ack & irq_req;

   intc_state #(.N_SRC(N_SRC)) u_state (
      .clk(clk), .rst_n(rst_n),
      .pri_wr(pri_wr), .pri_wdata(pri_wdata),
      .ge_wr(ge_wr), .ge_wdata(ge_t'(ge_wdata)),
      .take(take), .take_lvl(lvl), .reti(irq_reti),
      .pri(pri), .ge(ge), .hi_act(hi_act), .lo_act(lo_act)
   );

   assign ge_state = ge;
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
   parameter int                ADDR_W = 21,
   parameter logic [ADDR_W-1:0] HI_VEC = 'h8,
   parameter logic [ADDR_W-1:0] LO_VEC = 'h18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prio_mode,
   input logic              irq_ack,
   input logic              irq_reti,
   input logic              irq_req,
   input logic [ADDR_W-1:0] irq_vec,
   input logic              wake,
   input logic [1:0]        ge_state,
   input logic              hi_act
);
   // R2: a request is only possible with some enabled flag
   a_r2_req_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> wake);

   // R3: legacy mode uses the high vector only
   a_r3_legacy_vec: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !prio_mode) |-> irq_vec == HI_VEC);

   // R4: a high request needs global enable bit 0
   a_r4_hi_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_vec == HI_VEC) |-> ge_state[0]);

   // R5: a low request needs priority mode and global enable bit 1
   a_r5_lo_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_vec == LO_VEC) |-> (prio_mode && ge_state[1]));

   // R6: taking a request clears the served level's enable
   a_r6_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req && irq_vec == HI_VEC) |=> !ge_state[0]);
   a_r6_lo_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req && irq_vec == LO_VEC) |=> !ge_state[1]);

   // R8: no low request while a high handler runs
   a_r8_no_lo_over_hi: assert property (@(posedge clk) disable iff (!rst_n)
      hi_act |-> !(irq_req && irq_vec == LO_VEC));

   // R9: return from a high handler restores enable bit 0
   a_r9_reti_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_reti && hi_act && !irq_ack) |=> ge_state[0]);
endmodule

bind two_level_intc intc_checker #(
   .ADDR_W(ADDR_W), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .prio_mode(prio_mode),
   .irq_ack(irq_ack), .irq_reti(irq_reti), .irq_req(irq_req),
   .irq_vec(irq_vec), .wake(wake), .ge_state(ge_state), .hi_act(hi_act)
);

// File: tb/test_two_level_intc.sv
`timescale 1ns/1ps
module test_two_level_intc;
   localparam int N_SRC  = 8;
   localparam int ADDR_W = 21;
   localparam logic [ADDR_W-1:0] HV = 21'h000008;
   localparam logic [ADDR_W-1:0] LV = 21'h000018;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N_SRC-1:0] src_flag = '0, src_en = '0, pri_wdata = '0;
   logic pri_wr = 0, ge_wr = 0, prio_mode = 0, irq_ack = 0, irq_reti = 0;
   logic [1:0] ge_wdata = '0;
   logic irq_req, wake;
   logic [ADDR_W-1:0] irq_vec;
   logic [1:0] ge_state;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   typedef struct {
      string             tag;
      logic              req;
      logic [ADDR_W-1:0] vec;
      logic              wk;
      logic [1:0]        ge;
   } item_t;
   item_t q[$];
   event  mon_ev;

   always #10 clk = ~clk;

   two_level_intc i_two_level_intc (
      .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
      .pri_wr(pri_wr), .pri_wdata(pri_wdata), .ge_wr(ge_wr), .ge_wdata(ge_wdata),
      .prio_mode(prio_mode), .irq_ack(irq_ack), .irq_reti(irq_reti),
      .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake), .ge_state(ge_state)
   );

   // monitor: pops expected items and compares with the outputs
   initial begin
      forever begin
         @(mon_ev);
         #1;
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_tests++;
            if (irq_req !== it.req || (it.req && irq_vec !== it.vec) ||
                wake !== it.wk || ge_state !== it.ge) begin
               n_fail++;
               $display("FAIL %s: req=%b vec=%h wake=%b ge=%b, expected req=%b vec=%h wake=%b ge=%b",
                        it.tag, irq_req, irq_vec, wake, ge_state,
                        it.req, it.vec, it.wk, it.ge);
            end
         end
      end
   end

   // driver side: queue an expectation for the current cycle
   task automatic expect_now(input string tag, input logic req,
                             input logic [ADDR_W-1:0] vec,
                             input logic wk, input logic [1:0] ge);
      item_t it;
      it.tag = tag; it.req = req; it.vec = vec; it.wk = wk; it.ge = ge;
      q.push_back(it);
      ->mon_ev;
      #3;
   endtask

   // pass one rising edge with the current strobes, then drop them
   task automatic tick();
      @(negedge clk);
      pri_wr = 0; ge_wr = 0; irq_ack = 0; irq_reti = 0;
   endtask

   task automatic write_ge(input logic [1:0] v);
      ge_wr = 1; ge_wdata = v; tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      expect_now("R1 reset state", 0, LV, 0, 2'b00);

      // priority mode, only high enable: reset priority is high
      prio_mode = 1;
      write_ge(2'b01);
      src_flag[5] = 1; src_en[5] = 1;
      expect_now("R1 priority bits reset high", 1, HV, 1, 2'b01);
      expect_now("R4 high source with enable bit 0", 1, HV, 1, 2'b01);

      // make source 5 low priority
      pri_wr = 1; pri_wdata = ~8'b0010_0000; tick();
      expect_now("R10 priority load, low blocked by bit 1 clear", 0, LV, 1, 2'b01);
      expect_now("R2 wake independent of global enables", 0, LV, 1, 2'b01);

      write_ge(2'b11);
      expect_now("R5 low request uses low vector", 1, LV, 1, 2'b11);
      src_flag[1] = 1; src_en[1] = 1;
      expect_now("R5 high wins over low", 1, HV, 1, 2'b11);
      src_flag[1] = 0;
      expect_now("R5 back to low", 1, LV, 1, 2'b11);

      // take the low request
      irq_ack = 1; tick();
      expect_now("R6 low ack clears bit 1", 0, LV, 1, 2'b01);

      // high source pre-empts the running low handler
      src_flag[1] = 1;
      expect_now("R7 high pre-empts low handler", 1, HV, 1, 2'b01);
      irq_ack = 1; tick();
      expect_now("R6 high ack clears bit 0", 0, LV, 1, 2'b00);

      src_flag[1] = 0;
      irq_reti = 1; tick();
      expect_now("R9 reti ends high handler first", 0, LV, 1, 2'b01);
      irq_reti = 1; tick();
      expect_now("R9 reti then ends low handler", 1, LV, 1, 2'b11);
      irq_reti = 1; tick();
      expect_now("R9 reti with no handler is no-op", 1, LV, 1, 2'b11);

      // high handler holds off low requests
      src_en[5] = 0; src_flag[1] = 1;
      expect_now("R4 high request again", 1, HV, 1, 2'b11);
      irq_ack = 1; tick();
      src_flag[1] = 0; src_en[5] = 1;
      expect_now("R8 low blocked during high handler", 0, LV, 1, 2'b10);
      irq_reti = 1; tick();
      expect_now("R9 low granted after high returns", 1, LV, 1, 2'b11);

      // ack wins over same-cycle enable write
      irq_ack = 1; ge_wr = 1; ge_wdata = 2'b11; tick();
      expect_now("R6 ack overrides ge write", 0, LV, 1, 2'b01);
      irq_reti = 1; tick();

      write_ge(2'b00);
      expect_now("R2 wake with enables clear", 0, LV, 1, 2'b00);
      src_en[5] = 0;
      expect_now("R2 flag without enable no wake", 0, LV, 0, 2'b00);

      // legacy mode
      prio_mode = 0;
      write_ge(2'b01);
      src_flag[6] = 1; src_en[6] = 1;
      expect_now("R3 peripheral needs bit 1", 0, LV, 1, 2'b01);
      write_ge(2'b11);
      expect_now("R3 peripheral with both bits", 1, HV, 1, 2'b11);
      src_flag[6] = 0; src_en[5] = 1;
      expect_now("R3 low priority bit ignored in legacy", 1, HV, 1, 2'b11);
      src_en[5] = 0;
      write_ge(2'b01);
      src_flag[0] = 1; src_en[0] = 1;
      expect_now("R3 core source with bit 0 only", 1, HV, 1, 2'b01);
      irq_ack = 1; tick();
      expect_now("R6 legacy ack clears bit 0", 0, LV, 1, 2'b00);
      irq_reti = 1; tick();
      expect_now("R9 legacy reti restores bit 0", 1, HV, 1, 2'b01);

      rst_n = 0; tick(); rst_n = 1; @(negedge clk);
      expect_now("R1 state after second reset", 0, LV, 1, 2'b00);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule